// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Per-Word Valid Bits

This block sits between a processor load/store port and a word-wide memory port. It is a direct-mapped cache. Each line keeps one tag, but every word of the line has its own valid bit. A store never causes a line fetch. The stored word goes into the line at once and its valid bit is set. If the tag differed, the line is re-tagged and every other word of that line is dropped. Every store is also passed straight on to memory, so dropping words never loses data.

Stores are processed as a two-stage pipeline. In the cycle a store is accepted, its tag and valid bits are updated and its data is parked in a one-entry pending-store register. That register is copied into the data array when the next store is accepted, so one store's tag check overlaps the previous store's array write. Loads compare their address against the pending-store register and take its data on a match.

A load hits only if the tag matches and the addressed word is valid. On a load miss, the pending store is first drained into the array. Then exactly one word is read from memory, returned to the processor and installed as valid.

Top module: `sbwt_cache`

## Requirements
- R1: After reset every word of every line is invalid, `cpu_rvalid` and `mem_req` are low, and the first load to any address misses and reads memory.
- R2: A store is accepted (`cpu_ready` high) in the cycle that memory acknowledges it. In that same cycle `mem_req` and `mem_we` are high and `mem_addr` and `mem_wdata` equal the store's address and data.
- R3: A store to a valid word of a line with a matching tag overwrites it, and a later load of that address hits and returns the new data.
- R4: A store to an invalid word of a line with a matching tag makes that word valid, so a later load of it hits.
- R5: A store whose tag differs from the line's tag re-tags the line and clears the valid bits of all other words. Loads of other words in that line then miss, and loads of the old tag also miss.
- R6: A load hit issues no memory request. It is accepted in its request cycle and `cpu_rvalid` with `cpu_rdata` follows one cycle later.
- R7: A load miss issues exactly one single-word memory read at the load address and returns that word. The word is installed as valid, so a repeated load hits.
- R8: A load of the address held in the pending-store register returns the stored data without a memory read, even when it comes directly after the store.
- R9: Back-to-back stores take one cycle each when memory acknowledges at once. For stores to the same address, the last one wins.
- R10: A load miss drains the pending store into the data array before the fill, so the pipeline is empty during the miss, and a later load of the stored address returns the stored data.
- R11: A load miss whose tag differs from the line's tag re-tags the line and leaves only the filled word valid.

Address layout (word address): bits [1:0] select the word within the line, bits [4:2] select the line, and bits [9:5] form the tag (default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_rvalid | output | 1 | Load data valid (one cycle after acceptance) |
| cpu_rdata | output | DATA_W | Load data |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepts the request; read data is valid in this cycle |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The hardest situation to reach is a pending store that is still in its register, not yet in the array, when something else needs that data. One case is a load of the same address in the very next cycle. The other is a load miss to another line, which must drain the register before the fill.

The bench reaches the first case by issuing a store and a load back to back, with no idle cycle between them. It reaches the second by placing a load miss to an unrelated line between a store and a re-read of the stored address.

Re-tagging is provoked by touching two tags that share a line index, with stores and with load misses. Memory read counts then show which words were dropped.

// File: rtl/sbwt_pkg.sv
package sbwt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } sbwt_state_e;
endpackage

// File: rtl/sbwt_tag_store.sv
module sbwt_tag_store #(
    parameter int LINES = 8,
    parameter int WORDS = 4,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [WORDS-1:0] rd_vld,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [TAG_W-1:0] wr_tag
);
    typedef struct packed {
        logic [LINES-1:0][TAG_W-1:0] tag;
        logic [LINES-1:0][WORDS-1:0] vld;
    } tstore_t;

    tstore_t ts_d, ts_q;

    always_comb begin
        ts_d = ts_q;
        if (wr_en) begin
            if (ts_q.tag[wr_idx] != wr_tag) begin
                // new owner of the line: every other word is dropped
                ts_d.tag[wr_idx] = wr_tag;
                ts_d.vld[wr_idx] = '0;
            end
            ts_d.vld[wr_idx][wr_off] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign rd_tag = ts_q.tag[rd_idx];
    assign rd_vld = ts_q.vld[rd_idx];

    // R4: any update leaves the written word valid under the written tag
    p_wr_marks_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ts_q.vld[$past(wr_idx)][$past(wr_off)] &&
                   ts_q.tag[$past(wr_idx)] == $past(wr_tag)));

    // R5 / R11: a re-tag leaves exactly one valid word in the line
    p_retag_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ts_q.tag[wr_idx] != wr_tag) |=> $countones(ts_q.vld[$past(wr_idx)]) == 1);
endmodule

// File: rtl/sbwt_data_store.sv
module sbwt_data_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int LOC_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [LOC_W-1:0]  rd_loc,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [LOC_W-1:0]  wr_loc,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] arr_d [DEPTH];
    logic [DATA_W-1:0] arr_q [DEPTH];

    always_comb begin
        arr_d = arr_q;
        if (wr_en) arr_d[wr_loc] = wr_data;
    end

    always_ff @(posedge clk) begin
        arr_q <= arr_d;
    end

    assign rd_data = arr_q[rd_loc];
endmodule

// File: rtl/sbwt_cache.sv
module sbwt_cache
    import sbwt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int LOC_W = IDX_W + OFF_W;
    localparam int TAG_W = ADDR_W - LOC_W;

    typedef struct packed {
        sbwt_state_e       st;
        logic              pend_vld;
        logic [ADDR_W-1:0] pend_addr;
        logic [DATA_W-1:0] pend_data;
        logic [ADDR_W-1:0] miss_addr;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  line_tag;
    logic [WORDS-1:0]  line_vld;
    logic              look_hit;
    logic              pend_match;
    logic              ts_wr;
    logic              ds_wr;
    logic [LOC_W-1:0]  ds_wloc;
    logic [DATA_W-1:0] ds_wdata;
    logic [DATA_W-1:0] ds_rdata;

    assign look_addr  = (ctl_q.st == ST_FILL) ? ctl_q.miss_addr : cpu_addr;
    assign look_hit   = (line_tag == look_addr[ADDR_W-1:LOC_W]) && line_vld[look_addr[OFF_W-1:0]];
    assign pend_match = ctl_q.pend_vld && (ctl_q.pend_addr == cpu_addr);

    sbwt_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (look_addr[LOC_W-1:OFF_W]),
        .rd_tag (line_tag),
        .rd_vld (line_vld),
        .wr_en  (ts_wr),
        .wr_idx (look_addr[LOC_W-1:OFF_W]),
        .wr_off (look_addr[OFF_W-1:0]),
        .wr_tag (look_addr[ADDR_W-1:LOC_W])
    );

    sbwt_data_store #(.DEPTH(LINES * WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_loc  (cpu_addr[LOC_W-1:0]),
        .rd_data (ds_rdata),
        .wr_en   (ds_wr),
        .wr_loc  (ds_wloc),
        .wr_data (ds_wdata)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        cpu_ready    = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = cpu_addr;
        mem_wdata    = cpu_wdata;
        ts_wr        = 1'b0;
        ds_wr        = 1'b0;
        ds_wloc      = ctl_q.pend_addr[LOC_W-1:0];
        ds_wdata     = ctl_q.pend_data;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req && cpu_we) begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                    if (mem_ack) begin
                        // stage 1 of this store, stage 2 of the previous one
                        cpu_ready       = 1'b1;
                        ts_wr           = 1'b1;
                        ds_wr           = ctl_q.pend_vld;
                        ctl_d.pend_vld  = 1'b1;
                        ctl_d.pend_addr = cpu_addr;
                        ctl_d.pend_data = cpu_wdata;
                    end
                end else if (cpu_req && look_hit) begin
                    cpu_ready    = 1'b1;
                    ctl_d.rvalid = 1'b1;
                    ctl_d.rdata  = pend_match ? ctl_q.pend_data : ds_rdata;
                end else if (cpu_req) begin
                    // empty the store pipeline before servicing the miss
                    ds_wr           = ctl_q.pend_vld;
                    ctl_d.pend_vld  = 1'b0;
                    ctl_d.miss_addr = cpu_addr;
                    ctl_d.st        = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = ctl_q.miss_addr;
                if (mem_ack) begin
                    cpu_ready    = 1'b1;
                    ts_wr        = 1'b1;
                    ds_wr        = 1'b1;
                    ds_wloc      = ctl_q.miss_addr[LOC_W-1:0];
                    ds_wdata     = mem_rdata;
                    ctl_d.rvalid = 1'b1;
                    ctl_d.rdata  = mem_rdata;
                    ctl_d.st     = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cpu_rvalid = ctl_q.rvalid;
    assign cpu_rdata  = ctl_q.rdata;

    // R10: no store is pending while a miss is serviced
    p_fill_pipe_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FILL) |-> !ctl_q.pend_vld);

    // R2: an accepted store is on the memory port in the same cycle
    p_store_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |->
            (mem_req && mem_we && mem_ack && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

    // R6: an accepted load delivers data on the following cycle
    p_load_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready) |=> cpu_rvalid);

    // R6: a load accepted without a fill touches no memory
    p_hit_no_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && cpu_req && !cpu_we && cpu_ready) |-> !mem_req);

    // R7: a fill request stays steady until acknowledged
    p_fill_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/sbwt_cache_tb.sv
module sbwt_cache_tb;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int MSIZE  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_ready, cpu_rvalid;
    logic [DATA_W-1:0] cpu_rdata;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    logic [DATA_W-1:0] model  [MSIZE];
    logic [DATA_W-1:0] shadow [MSIZE];
    logic [1:0]        lat;
    int                rd_cnt = 0;
    int                wr_cnt = 0;
    int                cyc = 0;
    int                checks = 0;
    int                errors = 0;
    bit                finished = 0;

    always #10 clk = ~clk;

    sbwt_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: writes acknowledged at once, reads after two wait cycles
    assign mem_ack   = mem_req && (mem_we || lat == 2'd2);
    assign mem_rdata = model[mem_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) lat <= '0;
        else if (mem_req && !mem_we && !mem_ack) lat <= lat + 2'd1;
        else lat <= '0;
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                model[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
        return {tag[4:0], idx[2:0], off[1:0]};
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        shadow[a] = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d, output int mrd);
        int start;
        start = rd_cnt;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        check(cpu_rvalid == 1'b1, "R6 rvalid after accept", cpu_rvalid, 1);
        d   = cpu_rdata;
        mrd = rd_cnt - start;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] d; int m;
        check(cpu_rvalid == 1'b0, "R1 rvalid low", cpu_rvalid, 0);
        check(mem_req == 1'b0, "R1 mem_req low", mem_req, 0);
        do_read(mk(0, 0, 0), d, m);
        check(m == 1, "R1 first load misses", m, 1);
        check(d == shadow[mk(0, 0, 0)], "R7 miss data", d, shadow[mk(0, 0, 0)]);
    endtask

    task automatic t_fill();
        logic [DATA_W-1:0] d; int m;
        do_read(mk(1, 1, 2), d, m);
        check(m == 1, "R7 one memory read", m, 1);
        check(d == shadow[mk(1, 1, 2)], "R7 fill data", d, shadow[mk(1, 1, 2)]);
        do_read(mk(1, 1, 2), d, m);
        check(m == 0, "R6 repeat load hits", m, 0);
        check(d == shadow[mk(1, 1, 2)], "R6 hit data", d, shadow[mk(1, 1, 2)]);
    endtask

    task automatic t_store_hit();
        logic [DATA_W-1:0] d; int m, w0;
        w0 = wr_cnt;
        do_write(mk(1, 1, 2), 32'hDEAD_0001);
        check(wr_cnt == w0 + 1, "R2 store sent to memory", wr_cnt - w0, 1);
        check(model[mk(1, 1, 2)] == 32'hDEAD_0001, "R2 memory holds store", model[mk(1, 1, 2)], 32'hDEAD_0001);
        do_write(mk(0, 4, 0), 32'h0000_0404);   // push first store out of pending register
        do_read(mk(1, 1, 2), d, m);
        check(m == 0, "R3 store hit stays valid", m, 0);
        check(d == 32'hDEAD_0001, "R3 new data", d, 32'hDEAD_0001);
    endtask

    task automatic t_store_invalid_word();
        logic [DATA_W-1:0] d; int m;
        do_write(mk(1, 1, 3), 32'hBEEF_0003);
        do_write(mk(0, 4, 1), 32'h0000_0405);
        do_read(mk(1, 1, 3), d, m);
        check(m == 0, "R4 word made valid", m, 0);
        check(d == 32'hBEEF_0003, "R4 data", d, 32'hBEEF_0003);
    endtask

    task automatic t_store_retag();
        logic [DATA_W-1:0] d; int m;
        do_write(mk(4, 1, 0), 32'hCAFE_4100);
        do_read(mk(4, 1, 0), d, m);
        check(m == 0, "R5 written word hits", m, 0);
        check(d == 32'hCAFE_4100, "R5 written data", d, 32'hCAFE_4100);
        do_read(mk(4, 1, 2), d, m);
        check(m == 1, "R5 sibling word dropped", m, 1);
        do_read(mk(1, 1, 3), d, m);
        check(m == 1, "R5 old tag misses", m, 1);
        check(d == 32'hBEEF_0003, "R5 data kept in memory", d, 32'hBEEF_0003);
    endtask

    task automatic t_forward();
        logic [DATA_W-1:0] d; int m;
        do_write(mk(2, 3, 1), 32'h1234_5678);
        do_read(mk(2, 3, 1), d, m);
        check(m == 0, "R8 no memory read", m, 0);
        check(d == 32'h1234_5678, "R8 forwarded data", d, 32'h1234_5678);
    endtask

    task automatic t_back_to_back();
        logic [DATA_W-1:0] d; int m, c0;
        c0 = cyc;
        do_write(mk(3, 2, 0), 32'hAAAA_0000);
        do_write(mk(3, 2, 1), 32'hAAAA_0001);
        do_write(mk(3, 2, 1), 32'hBBBB_0001);
        check(cyc - c0 == 3, "R9 one cycle per store", cyc - c0, 3);
        do_read(mk(3, 2, 1), d, m);
        check(d == 32'hBBBB_0001 && m == 0, "R9 last store wins", d, 32'hBBBB_0001);
        do_read(mk(3, 2, 0), d, m);
        check(d == 32'hAAAA_0000 && m == 0, "R9 earlier store kept", d, 32'hAAAA_0000);
    endtask

    task automatic t_flush();
        logic [DATA_W-1:0] d; int m;
        do_write(mk(3, 5, 0), 32'h5555_3500);
        do_read(mk(0, 6, 0), d, m);
        check(m == 1, "R10 unrelated miss", m, 1);
        do_read(mk(3, 5, 0), d, m);
        check(m == 0, "R10 stored word hits", m, 0);
        check(d == 32'h5555_3500, "R10 drained data", d, 32'h5555_3500);
    endtask

    task automatic t_load_retag();
        logic [DATA_W-1:0] d; int m;
        do_read(mk(0, 7, 0), d, m);
        do_read(mk(0, 7, 1), d, m);
        do_read(mk(0, 7, 1), d, m);
        check(m == 0, "R11 line filled", m, 0);
        do_read(mk(5, 7, 0), d, m);
        check(m == 1 && d == shadow[mk(5, 7, 0)], "R11 retag fill", d, shadow[mk(5, 7, 0)]);
        do_read(mk(5, 7, 1), d, m);
        check(m == 1, "R11 sibling invalid", m, 1);
        do_read(mk(0, 7, 0), d, m);
        check(m == 1, "R11 old tag gone", m, 1);
        check(d == shadow[mk(0, 7, 0)], "R11 old tag data", d, shadow[mk(0, 7, 0)]);
    endtask

    initial begin
        for (int i = 0; i < MSIZE; i++) begin
            model[i]  = 32'hA500_0000 | i;
            shadow[i] = 32'hA500_0000 | i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_store_hit();
        t_store_invalid_word();
        t_store_retag();
        t_forward();
        t_back_to_back();
        t_flush();
        t_load_retag();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule